// File: doc/BRIEF.md
# Early Partial-Address Store-Queue Dependence Checker

This block is a store queue that decides memory dependences for loads before their full effective address is known. The low 18 bits of a load's address reach the block early over a narrow, fast path. The block compares that slice against every older store in the queue and reports one of three verdicts: no dependence, a possible dependence, or a certain conflict. It also hands back the 8-bit cache set index from the slice, so that the data and tag arrays can be read while the rest of the address is still on its way.

When the full address of the load arrives later, the block repeats the check on all address bits against the stores that were older than the load at lookup time and are still queued. A load that the early check flagged only because of an alias on the low bits is released at this point, and a counter output records how many such false dependences were cleared. A store whose address has not been written yet counts as a conflict for every younger load in both checks.

Stores are allocated in program order at the tail, receive their address later by index, and retire from the head. A load is tracked in one of a few load slots named by an identifier that the caller chooses. Only stores present in the queue before the lookup cycle are older than the load.

Top module: `sq_partial_disambig`

## Requirements
- R1: After reset the queue is empty, no early index, partial result or full result is valid, and the false-dependence count is 0.
- R2: One cycle after a lookup, `early_set_valid` is 1 and `early_set` equals bits [7:0] of the looked-up slice.
- R3: A lookup's partial verdict appears exactly 3 cycles after the lookup cycle, with the load identifier echoed; verdicts are encoded 0 = none, 1 = maybe, 2 = conflict.
- R4: If any older store with a known address matches the load on address bits [17:0], the partial verdict is maybe (1), even when higher address bits differ.
- R5: An older store whose address is still unknown makes both the partial and the full verdict conflict (2).
- R6: A store allocated in the lookup cycle or later is never considered for that load, in either check.
- R7: A full-address check produces its verdict exactly 5 cycles after the request, with the identifier echoed: conflict (2) if any still-queued older store matches on all address bits, none (0) otherwise.
- R8: When the partial verdict was maybe and the full verdict is none, the full result carries `full_res_release` = 1 and the false-dependence count rises by 1, visible one cycle after that result; it changes at no other time.
- R9: A store retired from the head is no longer considered by later lookups or by full checks of loads already tracked.
- R10: Store entries are allocated in ring order; `st_alloc_idx` gives the index the next allocation will take, starting at 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_alloc_valid | input | 1 | Allocate a store entry at the tail |
| st_alloc_idx | output | 4 | Index the next allocation takes |
| st_addr_valid | input | 1 | Write a store's full address |
| st_addr_idx | input | 4 | Entry receiving the address |
| st_addr | input | 32 | Full store address |
| st_retire_valid | input | 1 | Retire the oldest store |
| ld_req_valid | input | 1 | Early lookup of a load |
| ld_req_id | input | 2 | Load slot identifier |
| ld_req_part | input | 18 | Low address slice of the load |
| early_set_valid | output | 1 | Early set index valid |
| early_set | output | 8 | Cache set index for array prefetch |
| part_res_valid | output | 1 | Partial verdict valid |
| part_res_id | output | 2 | Load identifier of the partial verdict |
| part_res_verdict | output | 2 | Partial verdict (0 none, 1 maybe, 2 conflict) |
| ld_full_valid | input | 1 | Full-address check request |
| ld_full_id | input | 2 | Load slot identifier |
| ld_full_addr | input | 32 | Full load address |
| full_res_valid | output | 1 | Full verdict valid |
| full_res_id | output | 2 | Load identifier of the full verdict |
| full_res_verdict | output | 2 | Full verdict (0 none, 2 conflict) |
| full_res_release | output | 1 | A false dependence was cleared |
| false_dep_count | output | 16 | Count of cleared false dependences |

## Verification
A store allocation and a load lookup can land in the same cycle, and the ordering between them decides which stores the load must respect. The bench provokes this by raising both strobes on one edge while the new store has no address, which would force a conflict if it were counted; a none verdict from both checks shows that the store was treated as younger. Retirement racing a tracked load is provoked as well: a store retires between a load's lookup and its full check, and the full verdict must drop it.

// File: rtl/sq_pkg.sv
package sq_pkg;

    localparam int PART_W = 18;
    localparam int SET_W  = 8;

    typedef enum logic [1:0] {
        DEP_NONE  = 2'd0,
        DEP_MAYBE = 2'd1,
        DEP_HIT   = 2'd2
    } dep_e;

    // Early slice: an unknown older store forces a conflict, a slice alias only a maybe.
    function automatic dep_e grade_partial(input logic any_unknown, input logic any_alias);
        if (any_unknown)    return DEP_HIT;
        else if (any_alias) return DEP_MAYBE;
        else                return DEP_NONE;
    endfunction

    // Full address: the answer is exact, so there is no maybe.
    function automatic dep_e grade_full(input logic any_unknown, input logic any_match);
        return (any_unknown || any_match) ? DEP_HIT : DEP_NONE;
    endfunction

endpackage

// File: rtl/sq_delay_pipe.sv
module sq_delay_pipe #(
    parameter int W = 8,
    parameter int D = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    logic [D-1:0] vq;
    logic [W-1:0] dq [D];

    always_ff @(posedge clk) begin
        if (rst) begin
            vq <= '0;
        end else begin
            vq[0] <= in_valid;
            for (int i = 1; i < D; i++) vq[i] <= vq[i-1];
        end
    end

    always_ff @(posedge clk) begin
        dq[0] <= in_data;
        for (int i = 1; i < D; i++) dq[i] <= dq[i-1];
    end

    assign out_valid = vq[D-1];
    assign out_data  = dq[D-1];
endmodule

// File: rtl/sq_store_table.sv
module sq_store_table
    import sq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     alloc,
    input  logic                     addr_wr,
    input  logic [$clog2(DEPTH)-1:0] addr_idx,
    input  logic [ADDR_W-1:0]        addr_val,
    input  logic                     retire,
    input  logic [PART_W-1:0]        cmp_part,
    input  logic [ADDR_W-1:0]        cmp_full,
    output logic [$clog2(DEPTH)-1:0] alloc_idx,
    output logic [DEPTH-1:0]         retire_mask,
    output logic [DEPTH-1:0]         vld,
    output logic [DEPTH-1:0]         known,
    output logic [DEPTH-1:0]         pmatch,
    output logic [DEPTH-1:0]         fmatch
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int OCC_W = $clog2(DEPTH + 1);

    logic [IDX_W-1:0]  head, tail;
    logic [OCC_W-1:0]  occ;
    logic [ADDR_W-1:0] addr_q [DEPTH];

    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            occ   <= '0;
            vld   <= '0;
            known <= '0;
        end else begin
            if (alloc) begin
                vld[tail]   <= 1'b1;
                known[tail] <= 1'b0;
                tail        <= step(tail);
            end
            if (addr_wr && vld[addr_idx]) known[addr_idx] <= 1'b1;
            if (retire) begin
                vld[head]   <= 1'b0;
                known[head] <= 1'b0;
                head        <= step(head);
            end
            occ <= occ + OCC_W'(alloc) - OCC_W'(retire);
        end
    end

    always_ff @(posedge clk) begin
        if (addr_wr && vld[addr_idx]) addr_q[addr_idx] <= addr_val;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign pmatch[g] = (addr_q[g][PART_W-1:0] == cmp_part);
        assign fmatch[g] = (addr_q[g] == cmp_full);
    end

    assign alloc_idx   = tail;
    assign retire_mask = retire ? (DEPTH'(1) << head) : '0;

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        alloc |-> (occ != OCC_W'(DEPTH) || retire));

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        retire |-> occ != '0);

    // R10
    ring_step_chk: assert property (@(posedge clk) disable iff (rst)
        alloc |=> tail == step($past(tail)));
endmodule

// File: rtl/sq_partial_disambig.sv
module sq_partial_disambig
    import sq_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int LD_SLOTS = 4,
    parameter int ADDR_W   = 32,
    parameter int PART_LAT = 3,
    parameter int FULL_LAT = 5,
    parameter int CNT_W    = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        st_alloc_valid,
    output logic [$clog2(DEPTH)-1:0]    st_alloc_idx,
    input  logic                        st_addr_valid,
    input  logic [$clog2(DEPTH)-1:0]    st_addr_idx,
    input  logic [ADDR_W-1:0]           st_addr,
    input  logic                        st_retire_valid,
    input  logic                        ld_req_valid,
    input  logic [$clog2(LD_SLOTS)-1:0] ld_req_id,
    input  logic [PART_W-1:0]           ld_req_part,
    output logic                        early_set_valid,
    output logic [SET_W-1:0]            early_set,
    output logic                        part_res_valid,
    output logic [$clog2(LD_SLOTS)-1:0] part_res_id,
    output logic [1:0]                  part_res_verdict,
    input  logic                        ld_full_valid,
    input  logic [$clog2(LD_SLOTS)-1:0] ld_full_id,
    input  logic [ADDR_W-1:0]           ld_full_addr,
    output logic                        full_res_valid,
    output logic [$clog2(LD_SLOTS)-1:0] full_res_id,
    output logic [1:0]                  full_res_verdict,
    output logic                        full_res_release,
    output logic [CNT_W-1:0]            false_dep_count
);
    localparam int LID_W = $clog2(LD_SLOTS);
    localparam int PW_W  = LID_W + 2;
    localparam int FW_W  = LID_W + 3;

    logic [DEPTH-1:0] vld, known, pmatch, fmatch, retire_mask;

    sq_store_table #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_table (
        .clk        (clk),
        .rst        (rst),
        .alloc      (st_alloc_valid),
        .addr_wr    (st_addr_valid),
        .addr_idx   (st_addr_idx),
        .addr_val   (st_addr),
        .retire     (st_retire_valid),
        .cmp_part   (ld_req_part),
        .cmp_full   (ld_full_addr),
        .alloc_idx  (st_alloc_idx),
        .retire_mask(retire_mask),
        .vld        (vld),
        .known      (known),
        .pmatch     (pmatch),
        .fmatch     (fmatch)
    );

    // Early lookup: only stores already queued (and not leaving now) are older.
    logic [DEPTH-1:0] older_now;
    dep_e             pv_now;
    assign older_now = vld & ~retire_mask;
    assign pv_now    = grade_partial(|(older_now & ~known), |(older_now & pmatch));

    logic [DEPTH-1:0] slot_mask [LD_SLOTS];
    dep_e             slot_pv   [LD_SLOTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < LD_SLOTS; s++) begin
                slot_mask[s] <= '0;
                slot_pv[s]   <= DEP_NONE;
            end
        end else begin
            for (int s = 0; s < LD_SLOTS; s++) begin
                if (ld_req_valid && ld_req_id == LID_W'(s)) begin
                    slot_mask[s] <= older_now;
                    slot_pv[s]   <= pv_now;
                end else begin
                    slot_mask[s] <= slot_mask[s] & ~retire_mask;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            early_set_valid <= 1'b0;
            early_set       <= '0;
        end else begin
            early_set_valid <= ld_req_valid;
            if (ld_req_valid) early_set <= ld_req_part[SET_W-1:0];
        end
    end

    // Full check against the older stores still queued.
    logic [DEPTH-1:0] chk_mask;
    dep_e             fv_now;
    logic             rel_now;
    assign chk_mask = slot_mask[ld_full_id] & vld & ~retire_mask;
    assign fv_now   = grade_full(|(chk_mask & ~known), |(chk_mask & fmatch));
    assign rel_now  = (slot_pv[ld_full_id] == DEP_MAYBE) && (fv_now == DEP_NONE);

    logic [PW_W-1:0] part_out;
    logic [FW_W-1:0] full_out;

    sq_delay_pipe #(.W(PW_W), .D(PART_LAT)) u_part_pipe (
        .clk      (clk),
        .rst      (rst),
        .in_valid (ld_req_valid),
        .in_data  ({ld_req_id, pv_now}),
        .out_valid(part_res_valid),
        .out_data (part_out)
    );

    sq_delay_pipe #(.W(FW_W), .D(FULL_LAT)) u_full_pipe (
        .clk      (clk),
        .rst      (rst),
        .in_valid (ld_full_valid),
        .in_data  ({ld_full_id, fv_now, rel_now}),
        .out_valid(full_res_valid),
        .out_data (full_out)
    );

    assign {part_res_id, part_res_verdict}                   = part_out;
    assign {full_res_id, full_res_verdict, full_res_release} = full_out;

    always_ff @(posedge clk) begin
        if (rst)                                    false_dep_count <= '0;
        else if (full_res_valid && full_res_release) false_dep_count <= false_dep_count + 1'b1;
    end

    // R2
    early_set_chk: assert property (@(posedge clk) disable iff (rst)
        ld_req_valid |=> early_set_valid && early_set == $past(ld_req_part[SET_W-1:0]));

    // R3
    part_code_chk: assert property (@(posedge clk) disable iff (rst)
        part_res_valid |-> part_res_verdict != 2'b11);

    // R8
    release_none_chk: assert property (@(posedge clk) disable iff (rst)
        (full_res_valid && full_res_release) |-> full_res_verdict == DEP_NONE);

    // R8
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (false_dep_count != $past(false_dep_count)) |-> $past(full_res_valid && full_res_release));

    // R7
    full_code_chk: assert property (@(posedge clk) disable iff (rst)
        full_res_valid |-> full_res_verdict != DEP_MAYBE);
endmodule

// File: tb/sq_partial_disambig_bench.sv
module sq_partial_disambig_bench;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst;
    logic        st_alloc_valid, st_addr_valid, st_retire_valid;
    logic [3:0]  st_alloc_idx, st_addr_idx;
    logic [31:0] st_addr;
    logic        ld_req_valid, ld_full_valid;
    logic [1:0]  ld_req_id, ld_full_id;
    logic [17:0] ld_req_part;
    logic [31:0] ld_full_addr;
    logic        early_set_valid, part_res_valid, full_res_valid, full_res_release;
    logic [7:0]  early_set;
    logic [1:0]  part_res_id, part_res_verdict, full_res_id, full_res_verdict;
    logic [15:0] false_dep_count;

    sq_partial_disambig u_sq_partial_disambig (.*);

    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic [31:0] addr;
        logic [1:0]  pv;
        logic [1:0]  fv;
        logic        rel;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{addr: 32'h1234_5ABC, pv: 2'd1, fv: 2'd2, rel: 1'b0},
        '{addr: 32'h9234_5ABC, pv: 2'd1, fv: 2'd0, rel: 1'b1},
        '{addr: 32'h0000_0100, pv: 2'd0, fv: 2'd0, rel: 1'b0},
        '{addr: 32'h00AB_CDE0, pv: 2'd1, fv: 2'd2, rel: 1'b0}
    };

    task automatic st_alloc();
        @(negedge clk); st_alloc_valid = 1;
        @(posedge clk); @(negedge clk); st_alloc_valid = 0;
    endtask

    task automatic st_write(input logic [3:0] idx, input logic [31:0] a);
        @(negedge clk); st_addr_valid = 1; st_addr_idx = idx; st_addr = a;
        @(posedge clk); @(negedge clk); st_addr_valid = 0;
    endtask

    task automatic st_ret();
        @(negedge clk); st_retire_valid = 1;
        @(posedge clk); @(negedge clk); st_retire_valid = 0;
    endtask

    // Lookup; result expected 3 edges after the lookup edge.
    task automatic lookup(input logic [1:0] id, input logic [31:0] a, input bit with_alloc,
                          input logic [1:0] exp_pv, input string req);
        @(negedge clk);
        ld_req_valid = 1; ld_req_id = id; ld_req_part = a[17:0];
        st_alloc_valid = with_alloc;
        @(posedge clk);
        @(negedge clk);
        ld_req_valid = 0; st_alloc_valid = 0;
        check("R2 early set", {early_set_valid, early_set}, {1'b1, a[7:0]});
        @(posedge clk);
        @(negedge clk);
        check("R3 partial not early", part_res_valid, 0);
        @(posedge clk);
        @(negedge clk);
        check({req, " partial verdict"}, {part_res_valid, part_res_id, part_res_verdict},
              {1'b1, id, exp_pv});
    endtask

    // Full check; result 5 edges after the request edge, count one edge later.
    task automatic full(input logic [1:0] id, input logic [31:0] a, input logic [1:0] exp_fv,
                        input logic exp_rel, input logic [15:0] exp_cnt, input string req);
        @(negedge clk);
        ld_full_valid = 1; ld_full_id = id; ld_full_addr = a;
        @(posedge clk);
        @(negedge clk);
        ld_full_valid = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R7 full not early", full_res_valid, 0);
        @(posedge clk);
        @(negedge clk);
        check({req, " full verdict"}, {full_res_valid, full_res_id, full_res_verdict, full_res_release},
              {1'b1, id, exp_fv, exp_rel});
        @(posedge clk);
        @(negedge clk);
        check("R8 false dep count", false_dep_count, exp_cnt);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] cnt;
        rst = 1; st_alloc_valid = 0; st_addr_valid = 0; st_retire_valid = 0;
        st_addr_idx = 0; st_addr = 0; ld_req_valid = 0; ld_req_id = 0; ld_req_part = 0;
        ld_full_valid = 0; ld_full_id = 0; ld_full_addr = 0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 0;
        @(negedge clk);
        // R1
        check("R1 reset outputs", {early_set_valid, part_res_valid, full_res_valid}, 0);
        check("R1 reset count", false_dep_count, 0);
        check("R10 first index", st_alloc_idx, 0);

        st_alloc();
        check("R10 next index", st_alloc_idx, 1);
        st_alloc();
        st_write(4'd0, 32'h1234_5ABC);
        st_write(4'd1, 32'h00AB_CDE0);

        // R4 R7 R8 vector walk
        cnt = 0;
        for (int i = 0; i < 4; i++) begin
            lookup(2'(i), VECS[i].addr, 0, VECS[i].pv, "R4");
            if (VECS[i].rel) cnt++;
            full(2'(i), VECS[i].addr, VECS[i].fv, VECS[i].rel, cnt, "R7");
        end

        // R5: store 2 without address
        st_alloc();
        lookup(2'd1, 32'h0000_0100, 0, 2'd2, "R5");
        full(2'd1, 32'h0000_0100, 2'd2, 1'b0, cnt, "R5");
        st_write(4'd2, 32'h7770_0100);
        lookup(2'd1, 32'h0000_0100, 0, 2'd1, "R4 alias");
        cnt++;
        full(2'd1, 32'h0000_0100, 2'd0, 1'b1, cnt, "R8 release");

        // R6: store allocated after lookup is younger
        lookup(2'd2, 32'h0BAD_0040, 0, 2'd0, "R6");
        st_alloc();
        st_write(4'd3, 32'h0BAD_0040);
        full(2'd2, 32'h0BAD_0040, 2'd0, 1'b0, cnt, "R6 later store");

        // R6: allocate in the same cycle as lookup; new store has no address
        check("R10 index before same-cycle", st_alloc_idx, 4);
        lookup(2'd3, 32'h00C0_FFEE, 1, 2'd0, "R6 same cycle");
        full(2'd3, 32'h00C0_FFEE, 2'd0, 1'b0, cnt, "R6 same cycle");
        check("R10 index after same-cycle", st_alloc_idx, 5);
        st_write(4'd4, 32'h4444_0000);

        // R9: retire between lookup and full check
        lookup(2'd1, 32'h1234_5ABC, 0, 2'd1, "R9 before retire");
        st_ret();
        st_ret();
        cnt++;
        full(2'd1, 32'h1234_5ABC, 2'd0, 1'b1, cnt, "R9 tracked load");
        lookup(2'd0, 32'h1234_5ABC, 0, 2'd0, "R9 after retire");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule